// File: doc/BRIEF.md
# UART Receive Queue with Line Status

This block sits between a UART's serial deserializer and its host register file. Each received character arrives on a one-cycle strobe together with three per-character error flags: parity, framing and break. The block queues each character with its flags. It presents the oldest character to the host and builds the 8-bit line status byte that the host reads. Beside the receive-side bits, the status byte carries two transmitter-empty bits taken straight from the transmit path.

The host configures the block through a FIFO control write. That write can enable the queue, empty the receive queue, request a transmit-queue flush, and choose the receive trigger level. With the queue disabled, the block behaves as a single holding register. Error status is kept per character. The parity, framing and break bits describe the character at the head of the queue, and a status read acknowledges them. A separate summary bit stays set while any queued character still carries an error.

Occupancy is tracked by a three-state machine (`occ_state_t`):
- OCC_EMPTY: no character held.
- OCC_PART: some characters held, below capacity.
- OCC_FULL: capacity reached.

The named transitions are:
- EMPTY→PART: push while capacity exceeds 1.
- EMPTY→FULL: push while capacity is 1.
- PART→FULL: push without pop reaches capacity.
- PART→EMPTY: pop without push removes the last character.
- FULL→PART: pop without push, capacity above 1.
- FULL→EMPTY: pop without push, capacity 1.
- any→EMPTY: receive flush.

A push together with a pop leaves the state unchanged.

Top module: `uart_rx_fifo_status`

## Requirements
- R1: After reset, the queue is disabled and empty. `rbr_data` is 0, `trig_hit`, `line_irq` and `tx_flush` are 0, and `lsr` equals {tsr&thr, thr} in bits 6:5 with every other bit 0.
- R2: Characters leave in arrival order. `rbr_data` shows the oldest held character, and a `rbr_rd` pulse removes it.
- R3: `lsr` bit 0 is 1 while at least one character is held and 0 once the last one has been read.
- R4: Capacity is 16 when FIFO control bit 0 is set and 1 when it is clear. A character that arrives at capacity without a same-cycle read is dropped, the held contents stay, and `lsr` bit 1 (overrun) sets. A character arriving with a same-cycle read of a full queue is accepted.
- R5: `lsr` bit 1 clears in the cycle after an `lsr_rd` pulse, unless a new overrun happens in that cycle.
- R6: `lsr` bits 2, 3 and 4 show the parity, framing and break flags of the head character. After an `lsr_rd` they read 0 until the head character is removed.
- R7: `line_irq` is 1 exactly when any of `lsr` bits 1 to 4 is 1.
- R8: `lsr` bit 7 is 1 while the queue is enabled and any held character carries an error flag, and it clears only once no such character remains. In single-register mode it is 0.
- R9: `lsr` bit 5 follows `thr_empty`, and `lsr` bit 6 is `thr_empty` AND `tsr_empty`.
- R10: FIFO control bits 7:6 select a trigger level of 1, 4, 8 or 14 for the values 00, 01, 10 and 11. `trig_hit` is 1 while the held count is at or above the level. In single-register mode the level is 1.
- R11: A FIFO control write with bit 1 set, or one whose bit 0 differs from the current enable, empties the receive queue in the next cycle. A character arriving in the same cycle is dropped without overrun, and `lsr` bit 1 is not cleared by it.
- R12: A FIFO control write with bit 2 set makes `tx_flush` 1 for exactly the following cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| rx_valid | input | 1 | One-cycle strobe: a received character is present |
| rx_data | input | 8 | Received character |
| rx_perr | input | 1 | Parity error flag of the character |
| rx_ferr | input | 1 | Framing error flag of the character |
| rx_brk | input | 1 | Break flag of the character |
| fcr_wr | input | 1 | FIFO control write strobe |
| fcr_wdata | input | 8 | FIFO control write value |
| rbr_rd | input | 1 | Host read of the receive buffer (removes head) |
| lsr_rd | input | 1 | Host read of the line status byte |
| thr_empty | input | 1 | Transmit holding register empty |
| tsr_empty | input | 1 | Transmit shift register empty |
| rbr_data | output | 8 | Head character, 0 when empty |
| lsr | output | 8 | Line status byte |
| trig_hit | output | 1 | Held count at or above trigger level |
| line_irq | output | 1 | Line-error interrupt request |
| tx_flush | output | 1 | One-cycle transmit-queue flush request |

## Verification
A corrupted read or write pointer shows up at `rbr_data` the next time the host reads. That happens one cycle after the pop, as an out-of-order or stale character. A wrong occupancy state shows up earlier: `lsr` bit 0, `trig_hit` or the overrun bit disagree with the number of characters pushed, in the cycle right after the offending push or pop. A miscounted error tally keeps `lsr` bit 7 set after the last erroneous character has left, or clears it early. This is visible the cycle after that character's pop. A stuck head acknowledge hides or repeats head flags on `lsr` bits 2 to 4 until the next pop.

// File: rtl/uart_rxq_pkg.sv
package uart_rxq_pkg;

    localparam int CHAR_W = 8;

    typedef struct packed {
        logic              brk;
        logic              ferr;
        logic              perr;
        logic [CHAR_W-1:0] data;
    } rxq_entry_t;

    typedef enum logic [1:0] {
        OCC_EMPTY = 2'd0,
        OCC_PART  = 2'd1,
        OCC_FULL  = 2'd2
    } occ_state_t;

    // receive trigger level selected by the two-bit control field
    function automatic int unsigned trig_level(input logic [1:0] sel);
        unique case (sel)
            2'b00:   return 1;
            2'b01:   return 4;
            2'b10:   return 8;
            default: return 14;
        endcase
    endfunction

endpackage

// File: rtl/rxq_ctrl.sv
module rxq_ctrl
    import uart_rxq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          rx_valid,
    input  logic          rbr_rd,
    input  logic          lsr_rd,
    input  logic          flush,
    input  logic          fifo_en,
    output logic          push,
    output logic          pop,
    output logic [AW-1:0] wptr,
    output logic [AW-1:0] rptr,
    output logic [CW-1:0] cnt,
    output occ_state_t    state,
    output logic          head_ack,
    output logic          ovr
);

    occ_state_t    state_n;
    logic [CW-1:0] cap;
    logic [CW-1:0] cnt_n;

    function automatic logic [AW-1:0] ptr_inc(input logic [AW-1:0] p);
        return (p == AW'(DEPTH - 1)) ? '0 : p + AW'(1);
    endfunction

    assign cap = fifo_en ? CW'(DEPTH) : CW'(1);

    // request qualification
    always_comb begin
        pop  = rbr_rd && (state != OCC_EMPTY) && !flush;
        push = rx_valid && !flush && ((state != OCC_FULL) || pop);
    end

    // next occupancy state
    always_comb begin
        state_n = state;
        if (flush) begin
            state_n = OCC_EMPTY;
        end else begin
            unique case (state)
                OCC_EMPTY: begin
                    if (push) state_n = (cap == CW'(1)) ? OCC_FULL : OCC_PART;
                end
                OCC_PART: begin
                    if (push && !pop)
                        state_n = (cnt + CW'(1) == cap) ? OCC_FULL : OCC_PART;
                    else if (pop && !push)
                        state_n = (cnt == CW'(1)) ? OCC_EMPTY : OCC_PART;
                end
                OCC_FULL: begin
                    if (pop && !push)
                        state_n = (cap == CW'(1)) ? OCC_EMPTY : OCC_PART;
                end
                default: state_n = OCC_EMPTY;
            endcase
        end
    end

    always_comb begin
        cnt_n = cnt;
        if (flush)              cnt_n = '0;
        else if (push && !pop)  cnt_n = cnt + CW'(1);
        else if (pop && !push)  cnt_n = cnt - CW'(1);
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= OCC_EMPTY;
            cnt   <= '0;
        end else begin
            state <= state_n;
            cnt   <= cnt_n;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            wptr     <= '0;
            rptr     <= '0;
            head_ack <= 1'b0;
            ovr      <= 1'b0;
        end else begin
            if (flush) begin
                wptr <= '0;
                rptr <= '0;
            end else begin
                if (push) wptr <= ptr_inc(wptr);
                if (pop)  rptr <= ptr_inc(rptr);
            end

            if (flush || pop)
                head_ack <= 1'b0;
            else if (lsr_rd && state != OCC_EMPTY)
                head_ack <= 1'b1;

            if (rx_valid && !flush && !push)
                ovr <= 1'b1;
            else if (lsr_rd)
                ovr <= 1'b0;
        end
    end

endmodule

// File: rtl/rxq_store.sv
module rxq_store
    import uart_rxq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          push,
    input  logic          pop,
    input  logic          flush,
    input  logic [AW-1:0] wptr,
    input  logic [AW-1:0] rptr,
    input  rxq_entry_t    wr_entry,
    output rxq_entry_t    head,
    output logic          err_any
);

    rxq_entry_t    mem [DEPTH];
    logic [CW-1:0] err_cnt;
    logic          wr_bad;
    logic          hd_bad;

    always_ff @(posedge clk) begin
        if (push) mem[wptr] <= wr_entry;
    end

    assign head   = mem[rptr];
    assign wr_bad = wr_entry.perr | wr_entry.ferr | wr_entry.brk;
    assign hd_bad = head.perr | head.ferr | head.brk;

    // tally of held characters that carry any error flag
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            err_cnt <= '0;
        end else if (flush) begin
            err_cnt <= '0;
        end else begin
            err_cnt <= err_cnt + CW'(push && wr_bad) - CW'(pop && hd_bad);
        end
    end

    assign err_any = (err_cnt != '0);

endmodule

// File: rtl/rxq_status.sv
module rxq_status
    import uart_rxq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  occ_state_t    state,
    input  logic [CW-1:0] cnt,
    input  logic          ovr,
    input  logic          head_ack,
    input  rxq_entry_t    head,
    input  logic          fifo_en,
    input  logic [1:0]    trig_sel,
    input  logic          err_any,
    input  logic          thr_empty,
    input  logic          tsr_empty,
    output logic [7:0]    rbr_data,
    output logic [7:0]    lsr,
    output logic          trig_hit,
    output logic          line_irq
);

    logic          held;
    logic [2:0]    hflags;
    logic [CW-1:0] level;
    int unsigned   tl;

    always_comb begin
        held   = (state != OCC_EMPTY);
        hflags = (held && !head_ack) ? {head.brk, head.ferr, head.perr} : 3'b000;

        tl = trig_level(trig_sel);
        if (tl > DEPTH) tl = DEPTH;
        level = fifo_en ? CW'(tl) : CW'(1);

        rbr_data = held ? head.data : '0;
        lsr      = {fifo_en & err_any, thr_empty & tsr_empty, thr_empty,
                    hflags, ovr, held};
        trig_hit = (cnt >= level);
        line_irq = ovr | (|hflags);
    end

endmodule

// File: rtl/uart_rx_fifo_status.sv
module uart_rx_fifo_status
    import uart_rxq_pkg::*;
#(
    parameter  int DEPTH = 16,
    localparam int AW    = $clog2(DEPTH),
    localparam int CW    = $clog2(DEPTH + 1)
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_valid,
    input  logic [7:0] rx_data,
    input  logic       rx_perr,
    input  logic       rx_ferr,
    input  logic       rx_brk,
    input  logic       fcr_wr,
    input  logic [7:0] fcr_wdata,
    input  logic       rbr_rd,
    input  logic       lsr_rd,
    input  logic       thr_empty,
    input  logic       tsr_empty,
    output logic [7:0] rbr_data,
    output logic [7:0] lsr,
    output logic       trig_hit,
    output logic       line_irq,
    output logic       tx_flush
);

    logic          fifo_en;
    logic [1:0]    trig_sel;
    logic          flush;
    logic          push, pop, head_ack, ovr, err_any;
    logic [AW-1:0] wptr, rptr;
    logic [CW-1:0] cnt;
    occ_state_t    occ_state;
    rxq_entry_t    wr_entry, head;

    // control register: bit0 enable, bit1 receive flush, bit2 transmit flush, 7:6 trigger
    assign flush = fcr_wr && (fcr_wdata[1] || (fcr_wdata[0] != fifo_en));

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            fifo_en  <= 1'b0;
            trig_sel <= 2'b00;
            tx_flush <= 1'b0;
        end else begin
            tx_flush <= fcr_wr && fcr_wdata[2];
            if (fcr_wr) begin
                fifo_en  <= fcr_wdata[0];
                trig_sel <= fcr_wdata[7:6];
            end
        end
    end

    assign wr_entry = '{brk: rx_brk, ferr: rx_ferr, perr: rx_perr, data: rx_data};

    rxq_ctrl #(.DEPTH(DEPTH)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .rx_valid (rx_valid),
        .rbr_rd   (rbr_rd),
        .lsr_rd   (lsr_rd),
        .flush    (flush),
        .fifo_en  (fifo_en),
        .push     (push),
        .pop      (pop),
        .wptr     (wptr),
        .rptr     (rptr),
        .cnt      (cnt),
        .state    (occ_state),
        .head_ack (head_ack),
        .ovr      (ovr)
    );

    rxq_store #(.DEPTH(DEPTH)) u_store (
        .clk      (clk),
        .rst_n    (rst_n),
        .push     (push),
        .pop      (pop),
        .flush    (flush),
        .wptr     (wptr),
        .rptr     (rptr),
        .wr_entry (wr_entry),
        .head     (head),
        .err_any  (err_any)
    );

    rxq_status #(.DEPTH(DEPTH)) u_status (
        .state     (occ_state),
        .cnt       (cnt),
        .ovr       (ovr),
        .head_ack  (head_ack),
        .head      (head),
        .fifo_en   (fifo_en),
        .trig_sel  (trig_sel),
        .err_any   (err_any),
        .thr_empty (thr_empty),
        .tsr_empty (tsr_empty),
        .rbr_data  (rbr_data),
        .lsr       (lsr),
        .trig_hit  (trig_hit),
        .line_irq  (line_irq)
    );

endmodule

// File: rtl/uart_rx_fifo_status_chk.sv
module uart_rx_fifo_status_chk
    import uart_rxq_pkg::*;
(
    input logic       clk,
    input logic       rst_n,
    input logic       rx_valid,
    input logic       rbr_rd,
    input logic       lsr_rd,
    input logic       fcr_wr,
    input logic [7:0] fcr_wdata,
    input logic [7:0] rbr_data,
    input logic [7:0] lsr,
    input logic       trig_hit,
    input logic       tx_flush,
    input occ_state_t occ
);

    a_r3_ready_after_arrival: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_valid && !fcr_wr) |=> lsr[0]);

    a_r4_full_keeps_head: assert property (@(posedge clk) disable iff (!rst_n)
        (occ == OCC_FULL && rx_valid && !rbr_rd && !fcr_wr) |=> ($stable(rbr_data) && lsr[1]));

    a_r5_overrun_cleared: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && !rx_valid) |=> !lsr[1]);

    a_r6_head_flags_acked: assert property (@(posedge clk) disable iff (!rst_n)
        (lsr_rd && lsr[0] && !rbr_rd && !fcr_wr) |=> (lsr[4:2] == 3'b000));

    a_r8_error_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        lsr[7] |-> lsr[0]);

    a_r10_trigger_needs_data: assert property (@(posedge clk) disable iff (!rst_n)
        trig_hit |-> lsr[0]);

    a_r11_flush_empties: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && fcr_wdata[1]) |=> !lsr[0]);

    a_r12_tx_flush_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        (fcr_wr && fcr_wdata[2]) |=> tx_flush);

    a_r12_tx_flush_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !(fcr_wr && fcr_wdata[2]) |=> !tx_flush);

endmodule

bind uart_rx_fifo_status uart_rx_fifo_status_chk u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .rx_valid  (rx_valid),
    .rbr_rd    (rbr_rd),
    .lsr_rd    (lsr_rd),
    .fcr_wr    (fcr_wr),
    .fcr_wdata (fcr_wdata),
    .rbr_data  (rbr_data),
    .lsr       (lsr),
    .trig_hit  (trig_hit),
    .tx_flush  (tx_flush),
    .occ       (occ_state)
);

// File: tb/uart_rx_fifo_status_bench.sv
`timescale 1ns/1ps
module uart_rx_fifo_status_bench;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       rx_valid = 1'b0;
    logic [7:0] rx_data = '0;
    logic       rx_perr = 1'b0, rx_ferr = 1'b0, rx_brk = 1'b0;
    logic       fcr_wr = 1'b0;
    logic [7:0] fcr_wdata = '0;
    logic       rbr_rd = 1'b0, lsr_rd = 1'b0;
    logic       thr_empty = 1'b1, tsr_empty = 1'b1;
    logic [7:0] rbr_data, lsr;
    logic       trig_hit, line_irq, tx_flush;

    int n_chk = 0;
    int n_bad = 0;
    bit done  = 1'b0;

    always #2 clk = ~clk;

    uart_rx_fifo_status u_uart_rx_fifo_status (.*);

    task automatic chk(input string req, input string what, input int got, input int exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s %s: actual %0h expected %0h", req, what, got, exp);
        end
    endtask

    // all tasks start and end at a falling edge
    task automatic push_char(input logic [7:0] d, input logic p, input logic f, input logic b);
        rx_valid = 1'b1; rx_data = d; rx_perr = p; rx_ferr = f; rx_brk = b;
        @(negedge clk);
        rx_valid = 1'b0; rx_perr = 1'b0; rx_ferr = 1'b0; rx_brk = 1'b0;
    endtask

    task automatic pop_char(output logic [7:0] d);
        d = rbr_data;
        rbr_rd = 1'b1;
        @(negedge clk);
        rbr_rd = 1'b0;
    endtask

    task automatic read_lsr(output logic [7:0] v);
        v = lsr;
        lsr_rd = 1'b1;
        @(negedge clk);
        lsr_rd = 1'b0;
    endtask

    task automatic write_fcr(input logic [7:0] v);
        fcr_wr = 1'b1; fcr_wdata = v;
        @(negedge clk);
        fcr_wr = 1'b0;
    endtask

    task automatic t_reset();
        chk("R1", "lsr", lsr, 8'h60);
        chk("R1", "rbr_data", rbr_data, 0);
        chk("R1", "trig_hit", trig_hit, 0);
        chk("R1", "line_irq", line_irq, 0);
        chk("R1", "tx_flush", tx_flush, 0);
    endtask

    task automatic t_single();
        logic [7:0] v;
        push_char(8'hA5, 0, 0, 0);
        chk("R3", "ready after arrival", lsr[0], 1);
        chk("R10", "single mode trigger", trig_hit, 1);
        push_char(8'h5A, 0, 0, 0);
        chk("R4", "head kept on overrun", rbr_data, 8'hA5);
        chk("R4", "overrun lsr", lsr, 8'h63);
        chk("R7", "irq on overrun", line_irq, 1);
        read_lsr(v);
        chk("R5", "lsr read value", v, 8'h63);
        chk("R5", "overrun cleared", lsr, 8'h61);
        pop_char(v);
        chk("R2", "popped data", v, 8'hA5);
        chk("R3", "empty after read", lsr, 8'h60);
    endtask

    task automatic t_swap();
        logic [7:0] v;
        push_char(8'h11, 0, 0, 0);
        v = rbr_data;
        rx_valid = 1'b1; rx_data = 8'h22; rbr_rd = 1'b1;
        @(negedge clk);
        rx_valid = 1'b0; rbr_rd = 1'b0;
        chk("R4", "read during full push data", v, 8'h11);
        chk("R4", "accepted with read", rbr_data, 8'h22);
        chk("R4", "no overrun with read", lsr[1], 0);
        pop_char(v);
        chk("R2", "second char", v, 8'h22);
    endtask

    task automatic t_trigger();
        int lv [4] = '{1, 4, 8, 14};
        for (int s = 0; s < 4; s++) begin
            write_fcr({2'(s), 6'b000001});
            for (int i = 0; i < lv[s] - 1; i++) push_char(8'(i), 0, 0, 0);
            chk("R10", $sformatf("below level sel=%0d", s), trig_hit, 0);
            push_char(8'hFF, 0, 0, 0);
            chk("R10", $sformatf("at level sel=%0d", s), trig_hit, 1);
            write_fcr({2'(s), 6'b000011});
            chk("R11", $sformatf("flush sel=%0d", s), lsr, 8'h60);
        end
    endtask

    task automatic t_depth();
        logic [7:0] v;
        write_fcr(8'hC3);
        for (int i = 0; i < 16; i++) push_char(8'h30 + 8'(i), 0, 0, 0);
        chk("R4", "sixteen held no overrun", lsr, 8'h61);
        chk("R10", "level 14 reached", trig_hit, 1);
        push_char(8'hEE, 0, 0, 0);
        chk("R4", "seventeenth overruns", lsr, 8'h63);
        read_lsr(v);
        for (int i = 0; i < 16; i++) begin
            pop_char(v);
            chk("R2", $sformatf("order %0d", i), v, 8'h30 + i);
        end
        chk("R4", "dropped char absent", lsr, 8'h60);
    endtask

    task automatic t_errors();
        logic [7:0] v;
        write_fcr(8'h03);
        push_char(8'h01, 0, 0, 0);
        push_char(8'h02, 1, 0, 0);
        push_char(8'h03, 0, 1, 1);
        chk("R8", "error summary", lsr, 8'hE1);
        chk("R7", "no irq clean head", line_irq, 0);
        pop_char(v);
        chk("R6", "parity at head", lsr, 8'hE5);
        chk("R7", "irq on parity", line_irq, 1);
        read_lsr(v);
        chk("R6", "lsr read value", v, 8'hE5);
        chk("R6", "flags acked", lsr, 8'hE1);
        chk("R7", "irq after ack", line_irq, 0);
        pop_char(v);
        chk("R6", "break framing at head", lsr, 8'hF9);
        pop_char(v);
        chk("R8", "summary cleared", lsr, 8'h60);
        write_fcr(8'h00);
        push_char(8'h44, 1, 0, 0);
        chk("R8", "no summary single mode", lsr, 8'h65);
        pop_char(v);
    endtask

    task automatic t_flush();
        logic [7:0] v;
        push_char(8'h10, 0, 0, 0);
        push_char(8'h20, 0, 0, 0);
        chk("R4", "overrun single", lsr, 8'h63);
        write_fcr(8'h02);
        chk("R11", "flush keeps overrun", lsr, 8'h62);
        read_lsr(v);
        push_char(8'h30, 0, 0, 0);
        write_fcr(8'h01);
        chk("R11", "enable change empties", lsr, 8'h60);
        fcr_wr = 1'b1; fcr_wdata = 8'h03; rx_valid = 1'b1; rx_data = 8'h77;
        @(negedge clk);
        fcr_wr = 1'b0; rx_valid = 1'b0;
        chk("R11", "same-cycle char dropped", lsr, 8'h60);
    endtask

    task automatic t_txflush();
        write_fcr(8'h05);
        chk("R12", "pulse after write", tx_flush, 1);
        @(negedge clk);
        chk("R12", "pulse one cycle", tx_flush, 0);
        write_fcr(8'h01);
        chk("R12", "no pulse without bit2", tx_flush, 0);
    endtask

    task automatic t_tx_inputs();
        thr_empty = 1'b1; tsr_empty = 1'b0; #1;
        chk("R9", "holding empty only", lsr[6:5], 2'b01);
        thr_empty = 1'b0; tsr_empty = 1'b1; #1;
        chk("R9", "holding busy", lsr[6:5], 2'b00);
        thr_empty = 1'b1; tsr_empty = 1'b1; #1;
        chk("R9", "both empty", lsr[6:5], 2'b11);
        @(negedge clk);
    endtask

    initial begin
        #800000;
        if (!done) begin
            n_chk++;
            n_bad++;
            $display("FAIL watchdog all requirements: actual hung expected finished");
            $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
            $finish;
        end
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_single();
        t_swap();
        t_trigger();
        t_depth();
        t_errors();
        t_flush();
        t_txflush();
        t_tx_inputs();
        done = 1'b1;
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
        $finish;
    end

endmodule